// File: doc/BRIEF.md
# Serial NAND Program/Erase Sequencer

This block runs the complete write side of a serial NAND device on its own. A single start pulse asks either for a block erase or for a page program. The block then issues each SPI transaction the operation needs, in order. It first sets the write latch. For an erase it sends the erase command with the row address of the block. For a program it loads the page cache in bursts of up to 32 bytes and then commits the page to the array. After that it reads the status register repeatedly until the device stops reporting busy.

When the operation ends, the block raises `done` for one cycle with a two-bit result. The result is `0` for success, `1` for a reported erase or program failure, and `2` when the device was still busy at the last permitted poll. Before it reports either of the two error codes, the block clears the write latch.

Program data enters through a byte stream with valid/ready handshaking. A byte is taken only in a cycle where `wr_valid` and `wr_ready` are both high. `wr_ready` is never raised unless `wr_valid` is already high, so the source may present a byte at any time and may withdraw it only after it has been taken. While the source has no byte ready, the serial clock stops low and chip select stays asserted. The SPI master shifter inside the block runs mode 0 and sends the most significant bit first.

Top module: `nand_pe_seq`

## Requirements
- R1: Every operation begins with a one-byte transaction 0x06, which has no address and no data, and chip select is low for the whole of it.
- R2: An erase of block B sends 0xD8 followed by three row bytes (most significant first) equal to B shifted left by 6. The status polls follow it.
- R3: A program of N bytes sends one or more load transactions, each carrying at most 32 data bytes. Each load is 0x84, then the 16-bit column (most significant first), then the data bytes. The column starts at the requested value and advances by the count loaded. The commit follows: 0x10 and three row bytes.
- R4: A status poll is the transaction 0x0F, 0xC0, then one byte read back. Bit 0 of that byte means busy. While busy, the block repeats the poll, and chip select stays high for at least POLL_CYC clocks between two polls.
- R5: If the MAX_POLLS-th poll still reads busy, the block sends 0x04 and then reports result 2.
- R6: Status bit 2 after an erase, or status bit 3 after a program, causes 0x04 and then result 1. The other fail bit is ignored for that operation, and the result is 0.
- R7: A successful operation ends with `done` high for exactly one cycle, result 0, and no 0x04. `busy` falls in the same cycle that `done` rises.
- R8: A program byte is taken only when `wr_valid` and `wr_ready` are both high. `wr_ready` is high only while `wr_valid` is high. While the source stalls, chip select stays low.
- R9: A start pulse that arrives while `busy` is high is ignored.
- R10: SPI mode 0. `sclk` is low whenever chip select is high. `mosi` changes only while `sclk` is low. Chip select goes high for at least one clock between any two transactions.
- R11: After reset, `cs_n` is 1, `sclk` is 0, `busy` is 0 and `done` is 0.
- R12: A program with N = 0 skips the load transaction and goes straight from write-enable to commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request, taken only when idle |
| op_erase | input | 1 | 1 = block erase, 0 = page program |
| blk | input | BLK_W | Block number for an erase |
| row | input | ROW_W | Page row for a program |
| col | input | COL_W | Start column for a program |
| len | input | LEN_W | Program byte count |
| wr_data | input | 8 | Program data byte |
| wr_valid | input | 1 | Program data byte present |
| wr_ready | output | 1 | Program data byte taken this cycle |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | 0 ok, 1 fail, 2 timeout; valid with `done` |
| sclk | output | 1 | SPI clock |
| cs_n | output | 1 | SPI chip select, active low |
| mosi | output | 1 | SPI data out |
| miso | input | 1 | SPI data in |

## Verification
Most internal faults show up on the SPI lines within one transaction. A wrong byte counter or column register puts a bad address or payload byte on `mosi`. Wrong burst bookkeeping changes the count of load transactions. A misread status byte changes the number of polls or the result code seen at `done`. A stuck handshake or a lost byte appears as a shifted data stream or as `done` never arriving, and the bench compares every recorded byte and every transaction boundary with the stream it expects.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;
  typedef enum logic [2:0] {
    TX_WEN, TX_ERASE, TX_LOAD, TX_EXEC, TX_STAT, TX_WDIS
  } txn_e;

  typedef enum logic [1:0] {
    ST_IDLE, ST_GAP, ST_XFER, ST_WAIT
  } seq_state_e;

  localparam logic [1:0] RES_OK   = 2'd0;
  localparam logic [1:0] RES_FAIL = 2'd1;
  localparam logic [1:0] RES_TMO  = 2'd2;

  localparam logic [7:0] OPC_WEN   = 8'h06;
  localparam logic [7:0] OPC_WDIS  = 8'h04;
  localparam logic [7:0] OPC_ERASE = 8'hD8;
  localparam logic [7:0] OPC_LOAD  = 8'h84;
  localparam logic [7:0] OPC_EXEC  = 8'h10;
  localparam logic [7:0] OPC_GETF  = 8'h0F;
  localparam logic [7:0] FEAT_STAT = 8'hC0;
endpackage

// File: rtl/nand_spi_shift.sv
module nand_spi_shift #(
  parameter int HALF_CLK = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic [7:0] tx,
  input  logic       miso,
  output logic       busy,
  output logic       done,
  output logic [7:0] rx,
  output logic       sclk,
  output logic       mosi
);
  localparam int DW = (HALF_CLK > 1) ? $clog2(HALF_CLK) : 1;

  logic [DW-1:0] div;
  logic [2:0]    bitn;
  logic [7:0]    sr;

  assign mosi = sr[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
      rx   <= '0;
      sclk <= 1'b0;
      sr   <= '0;
      div  <= '0;
      bitn <= '0;
    end else begin
      done <= 1'b0;
      if (go && !busy) begin
        sr   <= tx;
        busy <= 1'b1;
        bitn <= '0;
        div  <= '0;
      end else if (busy) begin
        if (div == DW'(HALF_CLK - 1)) begin
          div <= '0;
          if (!sclk) begin
            sclk <= 1'b1;
            rx   <= {rx[6:0], miso};
          end else begin
            sclk <= 1'b0;
            sr   <= {sr[6:0], 1'b0};
            bitn <= bitn + 3'd1;
            if (bitn == 3'd7) begin
              busy <= 1'b0;
              done <= 1'b1;
            end
          end
        end else begin
          div <= div + DW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/nand_poll_wait.sv
module nand_poll_wait #(
  parameter int POLL_CYC = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  localparam int CW = $clog2(POLL_CYC + 1);

  logic [CW-1:0] cnt;

  assign expired = run && (cnt == CW'(POLL_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (!run)    cnt <= '0;
    else if (!expired) cnt <= cnt + CW'(1);
  end
endmodule

// File: rtl/nand_pe_seq.sv
module nand_pe_seq
  import nand_seq_pkg::*;
#(
  parameter int HALF_CLK   = 2,
  parameter int POLL_CYC   = 5000,
  parameter int MAX_POLLS  = 200,
  parameter int BURST      = 32,
  parameter int BLK_W      = 10,
  parameter int ROW_W      = 16,
  parameter int COL_W      = 12,
  parameter int LEN_W      = 12,
  parameter int PAGE_SHIFT = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             op_erase,
  input  logic [BLK_W-1:0] blk,
  input  logic [ROW_W-1:0] row,
  input  logic [COL_W-1:0] col,
  input  logic [LEN_W-1:0] len,
  input  logic [7:0]       wr_data,
  input  logic             wr_valid,
  output logic             wr_ready,
  output logic             busy,
  output logic             done,
  output logic [1:0]       result,
  output logic             sclk,
  output logic             cs_n,
  output logic             mosi,
  input  logic             miso
);
  localparam int IDX_W = $clog2(BURST + 4);
  localparam int PW    = $clog2(MAX_POLLS + 1);

  seq_state_e       state;
  txn_e             txn;
  logic [IDX_W-1:0] idx, tx_len, burst_q;
  logic             op_q;
  logic [23:0]      row_q;
  logic [COL_W-1:0] col_q;
  logic [LEN_W-1:0] rem_q, rem_after;
  logic [PW-1:0]    polls_q, polls_n;
  logic [1:0]       res_q;
  logic             done_q;
  logic [1:0]       result_q;

  logic       sh_go, sh_busy, sh_done, need_data, last_byte, tmr_exp;
  logic [7:0] sh_tx, sh_rx;
  logic [15:0] col16;
  logic       st_busy, st_fail, rx_unused;

  function automatic logic [IDX_W-1:0] burst_of(input logic [LEN_W-1:0] r);
    return (r >= LEN_W'(BURST)) ? IDX_W'(BURST) : IDX_W'(r);
  endfunction

  assign col16     = 16'(col_q);
  assign need_data = (txn == TX_LOAD) && (idx >= IDX_W'(3));
  assign sh_go     = (state == ST_XFER) && !sh_busy && !sh_done && (!need_data || wr_valid);
  assign wr_ready  = sh_go && need_data;
  assign last_byte = sh_done && (idx == tx_len - IDX_W'(1));
  assign rem_after = rem_q - LEN_W'(burst_q);
  assign polls_n   = polls_q + PW'(1);
  assign st_busy   = sh_rx[0];
  assign st_fail   = op_q ? sh_rx[2] : sh_rx[3];
  assign rx_unused = ^{sh_rx[7:4], sh_rx[1]};

  always_comb begin
    tx_len = IDX_W'(1);
    sh_tx  = 8'h00;
    case (txn)
      TX_WEN:  sh_tx = OPC_WEN;
      TX_WDIS: sh_tx = OPC_WDIS;
      TX_ERASE, TX_EXEC: begin
        tx_len = IDX_W'(4);
        case (idx)
          IDX_W'(0): sh_tx = (txn == TX_ERASE) ? OPC_ERASE : OPC_EXEC;
          IDX_W'(1): sh_tx = row_q[23:16];
          IDX_W'(2): sh_tx = row_q[15:8];
          default:   sh_tx = row_q[7:0];
        endcase
      end
      TX_STAT: begin
        tx_len = IDX_W'(3);
        case (idx)
          IDX_W'(0): sh_tx = OPC_GETF;
          IDX_W'(1): sh_tx = FEAT_STAT;
          default:   sh_tx = 8'h00;
        endcase
      end
      TX_LOAD: begin
        tx_len = IDX_W'(3) + burst_q;
        case (idx)
          IDX_W'(0): sh_tx = OPC_LOAD;
          IDX_W'(1): sh_tx = col16[15:8];
          IDX_W'(2): sh_tx = col16[7:0];
          default:   sh_tx = wr_data;
        endcase
      end
      default: sh_tx = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      txn      <= TX_WEN;
      idx      <= '0;
      op_q     <= 1'b0;
      row_q    <= '0;
      col_q    <= '0;
      rem_q    <= '0;
      burst_q  <= '0;
      polls_q  <= '0;
      res_q    <= RES_OK;
      done_q   <= 1'b0;
      result_q <= RES_OK;
    end else begin
      done_q <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          op_q  <= op_erase;
          row_q <= op_erase ? (24'(blk) << PAGE_SHIFT) : 24'(row);
          col_q <= col;
          rem_q <= op_erase ? '0 : len;
          txn   <= TX_WEN;
          idx   <= '0;
          state <= ST_XFER;
        end
        ST_GAP:  state <= ST_XFER;
        ST_WAIT: if (tmr_exp) state <= ST_XFER;
        ST_XFER: if (sh_done) begin
          if (!last_byte) begin
            idx <= idx + IDX_W'(1);
          end else begin
            idx   <= '0;
            state <= ST_GAP;
            case (txn)
              TX_WEN: begin
                if (op_q)               txn <= TX_ERASE;
                else if (rem_q != '0) begin
                  txn     <= TX_LOAD;
                  burst_q <= burst_of(rem_q);
                end else                txn <= TX_EXEC;
              end
              TX_LOAD: begin
                col_q <= col_q + COL_W'(burst_q);
                rem_q <= rem_after;
                if (rem_after != '0) burst_q <= burst_of(rem_after);
                else                 txn <= TX_EXEC;
              end
              TX_ERASE, TX_EXEC: begin
                txn     <= TX_STAT;
                polls_q <= '0;
              end
              TX_STAT: begin
                polls_q <= polls_n;
                if (st_busy) begin
                  if (polls_n == PW'(MAX_POLLS)) begin
                    res_q <= RES_TMO;
                    txn   <= TX_WDIS;
                  end else begin
                    state <= ST_WAIT;
                  end
                end else if (st_fail) begin
                  res_q <= RES_FAIL;
                  txn   <= TX_WDIS;
                end else begin
                  state    <= ST_IDLE;
                  done_q   <= 1'b1;
                  result_q <= RES_OK;
                end
              end
              default: begin
                state    <= ST_IDLE;
                done_q   <= 1'b1;
                result_q <= res_q;
              end
            endcase
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy   = (state != ST_IDLE);
  assign cs_n   = (state != ST_XFER);
  assign done   = done_q;
  assign result = result_q;

  nand_spi_shift #(.HALF_CLK(HALF_CLK)) u_shift (
    .clk(clk), .rst_n(rst_n), .go(sh_go), .tx(sh_tx), .miso(miso),
    .busy(sh_busy), .done(sh_done), .rx(sh_rx), .sclk(sclk), .mosi(mosi)
  );

  nand_poll_wait #(.POLL_CYC(POLL_CYC)) u_wait (
    .clk(clk), .rst_n(rst_n), .run(state == ST_WAIT), .expired(tmr_exp)
  );
endmodule

// File: rtl/nand_pe_seq_chk.sv
module nand_pe_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       wr_valid,
  input logic       wr_ready,
  input logic       busy,
  input logic       done,
  input logic [1:0] result,
  input logic       sclk,
  input logic       cs_n,
  input logic       mosi
);
  AST_SCLK_LOW_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> !sclk); // R10
  AST_MOSI_HELD_HIGH_PHASE: assert property (@(posedge clk) disable iff (!rst_n) sclk |-> $stable(mosi)); // R10
  AST_READY_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n) wr_ready |-> wr_valid); // R8
  AST_READY_WHILE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n) wr_ready |-> (busy && !cs_n)); // R8
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R7
  AST_DONE_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy); // R7
  AST_BUSY_ENDS_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> done); // R7
  AST_RESULT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n) done |-> (result != 2'd3)); // R6
  AST_IDLE_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> cs_n); // R11
  AST_BUSY_ONLY_FROM_START: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(start)); // R9
endmodule

bind nand_pe_seq nand_pe_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .busy(busy), .done(done), .result(result), .sclk(sclk), .cs_n(cs_n), .mosi(mosi)
);

// File: tb/tb_nand_pe_seq.sv
`timescale 1ns/1ps
module tb_nand_pe_seq;
  localparam int POLL = 16;
  localparam int MAXP = 4;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, op_erase = 1'b0;
  logic [9:0] blk = '0;
  logic [15:0] row = '0;
  logic [11:0] col = '0, len = '0;
  logic [7:0] wr_data = '0;
  logic wr_valid = 1'b0, miso = 1'b0;
  logic wr_ready, busy, done, sclk, cs_n, mosi;
  logic [1:0] result;

  int n_cmp = 0, n_bad = 0;
  int got[$], expq[$];
  realtime fall_t[$], rise_t[$];
  int bitcnt = 0, cmd = 0, stat_reads = 0, busy_n = 0;
  logic [7:0] fin_stat = 8'h00, in_sr = 8'h00, out_sr = 8'h00;

  always #5 clk = ~clk;

  nand_pe_seq #(.HALF_CLK(1), .POLL_CYC(POLL), .MAX_POLLS(MAXP)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_erase(op_erase), .blk(blk), .row(row),
    .col(col), .len(len), .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .busy(busy), .done(done), .result(result), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
    .miso(miso)
  );

  // behavioural serial NAND responder
  always @(negedge cs_n) begin bitcnt = 0; fall_t.push_back($realtime); end
  always @(posedge cs_n) if (rst_n) begin
    got.push_back(-1);
    rise_t.push_back($realtime);
    if (cmd == 8'h0F) stat_reads++;
  end
  always @(posedge sclk) if (!cs_n) begin
    in_sr = {in_sr[6:0], mosi};
    bitcnt++;
    if (bitcnt % 8 == 0) begin
      got.push_back(int'(in_sr));
      if (bitcnt == 8) cmd = int'(in_sr);
    end
  end
  always @(negedge sclk) if (!cs_n) begin
    if (cmd == 8'h0F && bitcnt == 16) begin
      out_sr = (stat_reads < busy_n) ? 8'h01 : fin_stat;
      miso = out_sr[7];
    end else if (bitcnt > 16) begin
      out_sr = {out_sr[6:0], 1'b0};
      miso = out_sr[7];
    end
  end

  // per-clock protocol model comparison
  always @(negedge clk) if (rst_n) begin
    n_cmp++;
    if (cs_n && sclk) begin n_bad++; $display("FAIL R10 sclk=%0b with cs_n high, expected 0", sclk); end
    n_cmp++;
    if (!busy && !cs_n) begin n_bad++; $display("FAIL R11 cs_n=%0b while idle, expected 1", cs_n); end
    n_cmp++;
    if (wr_ready && !wr_valid) begin n_bad++; $display("FAIL R8 wr_ready=1 with wr_valid=0, expected 0"); end
  end

  task automatic check(string req, int act, int exp_v);
    n_cmp++;
    if (act != exp_v) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
    end
  endtask

  task automatic eb(int b); expq.push_back(b); endtask
  task automatic eend(); expq.push_back(-1); endtask
  task automatic estat(int n); for (int i = 0; i < n; i++) begin eb(8'h0F); eb(8'hC0); eb(8'h00); eend(); end endtask
  task automatic erow(int r); eb((r >> 16) & 255); eb((r >> 8) & 255); eb(r & 255); eend(); endtask
  function automatic int dbyte(int i); return (i * 7 + 3) & 255; endfunction

  task automatic prep(int bn, logic [7:0] fs);
    got.delete(); expq.delete(); fall_t.delete(); rise_t.delete();
    stat_reads = 0; busy_n = bn; fin_stat = fs; cmd = 0;
  endtask

  task automatic feed(int n, bit stall);
    for (int i = 0; i < n; i++) begin
      if (stall && (i % 3 == 1)) begin
        wr_valid = 1'b0;
        repeat (6) @(posedge clk);
        #1;
      end
      wr_data = dbyte(i); wr_valid = 1'b1;
      do @(posedge clk); while (!wr_ready);
      #1;
    end
    wr_valid = 1'b0;
  endtask

  task automatic kick(bit er, int b, int r, int c, int l);
    @(posedge clk); #1;
    op_erase = er; blk = 10'(b); row = 16'(r); col = 12'(c); len = 12'(l); start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
  endtask

  task automatic wait_done(string req, int exp_res);
    int n = 0;
    while (!done && n < 20000) begin @(posedge clk); #1; n++; end
    check({req, " done seen"}, int'(done), 1);
    check({req, " result"}, int'(result), exp_res);
    @(posedge clk); #1;
    check({req, " done one cycle"}, int'(done), 0);
    repeat (4) @(posedge clk); #1;
  endtask

  task automatic cmp_stream(string req);
    check({req, " stream length"}, got.size(), expq.size());
    for (int i = 0; i < expq.size() && i < got.size(); i++) check({req, " stream byte"}, got[i], expq[i]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #1;
    repeat (3) @(posedge clk);
    #1;
    check("R11 cs_n", int'(cs_n), 1);
    check("R11 sclk", int'(sclk), 0);
    check("R11 busy", int'(busy), 0);
    check("R11 done", int'(done), 0);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);

    // R1 R2 R4 R7: erase, two busy polls then ready
    prep(2, 8'h00);
    eb(8'h06); eend(); eb(8'hD8); erow(5 << 6); estat(3);
    kick(1, 5, 0, 0, 0);
    wait_done("R2", 0);
    cmp_stream("R1 R2");
    if (rise_t.size() >= 5 && fall_t.size() >= 5) begin
      for (int i = 0; i < 4; i++)
        check("R10 gap", int'((fall_t[i+1] - rise_t[i]) / 10.0 >= 1.0), 1);
      check("R4 poll spacing", int'((fall_t[3] - rise_t[2]) / 10.0 >= POLL), 1);
      check("R4 poll spacing", int'((fall_t[4] - rise_t[3]) / 10.0 >= POLL), 1);
    end else check("R4 transaction count", rise_t.size(), 5);

    // R6: erase fail bit on last block
    prep(0, 8'h04);
    eb(8'h06); eend(); eb(8'hD8); erow(1023 << 6); estat(1); eb(8'h04); eend();
    kick(1, 1023, 0, 0, 0);
    wait_done("R6 erase fail", 1);
    cmp_stream("R6 erase fail");

    // R6: program-fail bit is ignored on erase
    prep(0, 8'h08);
    eb(8'h06); eend(); eb(8'hD8); erow(7 << 6); estat(1);
    kick(1, 7, 0, 0, 0);
    wait_done("R6 erase ignores bit3", 0);
    cmp_stream("R6 erase ignores bit3");

    // R3 R8: 40-byte program with source stalls, two loads
    prep(1, 8'h00);
    eb(8'h06); eend();
    eb(8'h84); eb(8'h00); eb(8'h10); for (int i = 0; i < 32; i++) eb(dbyte(i)); eend();
    eb(8'h84); eb(8'h00); eb(8'h30); for (int i = 32; i < 40; i++) eb(dbyte(i)); eend();
    eb(8'h10); erow(16'h1234); estat(2);
    fork feed(40, 1'b1); join_none
    kick(0, 0, 16'h1234, 12'h010, 40);
    wait_done("R3", 0);
    cmp_stream("R3 R8");

    // R6: program fail
    prep(0, 8'h08);
    eb(8'h06); eend(); eb(8'h84); eb(8'h07); eb(8'hFE);
    for (int i = 0; i < 3; i++) eb(dbyte(i)); eend();
    eb(8'h10); erow(16'h0042); estat(1); eb(8'h04); eend();
    fork feed(3, 1'b0); join_none
    kick(0, 0, 16'h0042, 12'h7FE, 3);
    wait_done("R6 program fail", 1);
    cmp_stream("R6 program fail");

    // R6: erase-fail bit is ignored on program
    prep(0, 8'h04);
    eb(8'h06); eend(); eb(8'h84); eb(8'h00); eb(8'h00); eb(dbyte(0)); eend();
    eb(8'h10); erow(16'h0001); estat(1);
    fork feed(1, 1'b0); join_none
    kick(0, 0, 16'h0001, 0, 1);
    wait_done("R6 program ignores bit2", 0);
    cmp_stream("R6 program ignores bit2");

    // R5: device never ready
    prep(1000, 8'h00);
    eb(8'h06); eend(); eb(8'hD8); erow(3 << 6); estat(MAXP); eb(8'h04); eend();
    kick(1, 3, 0, 0, 0);
    wait_done("R5 timeout", 2);
    cmp_stream("R5 timeout");

    // R12: zero-length program
    prep(0, 8'h00);
    eb(8'h06); eend(); eb(8'h10); erow(16'hBEEF); estat(1);
    kick(0, 0, 16'hBEEF, 0, 0);
    wait_done("R12", 0);
    cmp_stream("R12");

    // R9: second start during an erase is ignored
    prep(1, 8'h00);
    eb(8'h06); eend(); eb(8'hD8); erow(9 << 6); estat(2);
    kick(1, 9, 0, 0, 0);
    repeat (10) @(posedge clk); #1;
    start = 1'b1; op_erase = 1'b0; len = 12'd4;
    @(posedge clk); #1;
    start = 1'b0;
    wait_done("R9", 0);
    repeat (40) @(posedge clk); #1;
    check("R9 stays idle", int'(busy), 0);
    cmp_stream("R9");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule